// File: doc/BRIEF.md
# DMA Channel Control Registers

This block holds the software-visible control state of one DMA channel that sits in front of a storage-bus controller. A processor reaches it through a simple word-addressed port with separate write and read strobes; four 32-bit registers sit behind it. Register 0 holds control and status, and register 1 holds the transfer address. Registers 2 and 3 are plain storage.

Writes to the control register are not stored as written. A version nibble is forced into the top bits. One control bit toggles itself under fixed rules. A reset bit sends a one-cycle reset pulse to the attached controller and clears the rest of the channel state. Loading the address register marks the control register as loaded. The controller reports interrupts on a set input, which latches a pending flag. The interrupt output is high while that flag and an enable bit are both set.

The data mover, address translation and the controller itself lie outside this block.

Top module: `dma_chan_regs`

## Requirements
- R1: The register index is byte-address bits [3:2]; bits [1:0] are ignored. Registers 2 and 3 store the written word unchanged and have no side effects.
- R2: Every write to register 0 stores bits [31:28] as 4'hA, whatever was written there.
- R3: A register-0 write with bit 7 set raises `dev_reset_o` for exactly the one cycle after the write edge. It clears registers 1, 2 and 3. Register 0 takes the written value with only the version rewrite applied, so bit 6 is stored as written.
- R4: A register-0 write with bit 7 clear and bit 6 set stores bit 6 as 0. A write of the all-zero word stores 32'hA000_0040.
- R5: `irq_o` is registered and equals the AND of register-0 bit 0 (pending) and bit 4 (enable). After a register-0 write with bit 4 clear, it is low in the next cycle.
- R6: A write to register 1 stores the address and also sets register-0 bit 26 (loaded).
- R7: A high `dev_irq_set` in a cycle sets register-0 bit 0 at that edge. If software writes register 0 in the same cycle, bit 0 is still stored as 1.
- R8: A read returns the register value held before the read edge. `bus_rdata` and `bus_rvalid` are valid one cycle after `bus_rd`, and `bus_rvalid` is high for one cycle per read.
- R9: Synchronous reset clears all four registers and drives `irq_o`, `dev_reset_o`, `bus_rvalid` and `xfer_to_mem_o` low.
- R10: `xfer_to_mem_o` mirrors register-0 bit 8; a 1 means data moves from the device into memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| dev_irq_set | input | 1 | Interrupt request from the controller |
| irq_o | output | 1 | Interrupt output |
| dev_reset_o | output | 1 | Reset pulse to the controller |
| xfer_to_mem_o | output | 1 | Transfer direction, 1 = device to memory |

## Verification
Some rules can be checked in every cycle against the block's stored control word and its ports. These are the forced version nibble, the loaded flag after an address write, the pending flag after an interrupt request, the single-cycle reset pulse, the interrupt drop after a disabling write, and the read-valid timing. The bench scenarios are needed for the rest. They show the bit-6 toggle and the zero-write rule, the clearing of the other registers on a reset write, and the same-cycle collision between a software write and an interrupt request. They also show that the address low bits are ignored and that readback values are correct. Those rules only become visible through data read back later.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned BIT_PEND    = 0;
  localparam int unsigned BIT_IEN     = 4;
  localparam int unsigned BIT_TOGGLE  = 6;
  localparam int unsigned BIT_RESET   = 7;
  localparam int unsigned BIT_TO_MEM  = 8;
  localparam int unsigned BIT_LOADED  = 26;
  localparam int unsigned VER_LSB     = 28;
  localparam logic [3:0]  VER_NIBBLE  = 4'hA;
  localparam int unsigned IDX_LSB     = 2;
endpackage

// File: rtl/dma_ctrl_rewrite.sv
module dma_ctrl_rewrite
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] stored,
  output logic              reset_req
);
  logic [DATA_W-1:0] mid;

  always_comb begin
    mid       = raw;
    reset_req = raw[BIT_RESET];
    if (!raw[BIT_RESET]) begin
      if (raw[BIT_TOGGLE]) begin
        mid[BIT_TOGGLE] = 1'b0;
      end else if (raw == '0) begin
        mid[BIT_TOGGLE] = 1'b1;
      end
    end
    stored = mid;
    stored[DATA_W-1:VER_LSB] = VER_NIBBLE;
  end
endmodule

// File: rtl/dma_aux_regs.sv
module dma_aux_regs #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  logic [IDX_W-1:0]               idx,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           clear,
  output logic [NUM_REGS-1:0][DATA_W-1:0] q
);
  assign q[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] r;
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        r <= '0;
      end else if (wr && idx == IDX_W'(i)) begin
        r <= wdata;
      end
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/dma_irq_out.sv
module dma_irq_out (
  input  logic clk,
  input  logic rst,
  input  logic pend_next,
  input  logic en_next,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else begin
      irq <= pend_next & en_next;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              dev_irq_set,
  output logic              irq_o,
  output logic              dev_reset_o,
  output logic              xfer_to_mem_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0]              idx;
  logic [DATA_W-1:0]             ctrl_q, ctrl_d, ctrl_wval;
  logic                          reset_req;
  logic                          wr_ctrl, wr_addr, chan_clear;
  logic [NUM_REGS-1:0][DATA_W-1:0] aux_q;

  assign idx     = bus_addr[IDX_LSB +: IDX_W];
  assign wr_ctrl = bus_wr && idx == '0;
  assign wr_addr = bus_wr && idx == IDX_W'(1);

  dma_ctrl_rewrite #(.DATA_W(DATA_W)) u_rewrite (
    .raw       (bus_wdata),
    .stored    (ctrl_wval),
    .reset_req (reset_req)
  );

  assign chan_clear = wr_ctrl && reset_req;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = ctrl_wval;
    if (wr_addr) ctrl_d[BIT_LOADED] = 1'b1;
    if (dev_irq_set) ctrl_d[BIT_PEND] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      dev_reset_o <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      dev_reset_o <= chan_clear;
    end
  end

  dma_aux_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_aux (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr && idx != '0),
    .idx   (idx),
    .wdata (bus_wdata),
    .clear (chan_clear),
    .q     (aux_q)
  );

  dma_irq_out u_irq (
    .clk       (clk),
    .rst       (rst),
    .pend_next (ctrl_d[BIT_PEND]),
    .en_next   (ctrl_d[BIT_IEN]),
    .irq       (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= (idx == '0) ? ctrl_q : aux_q[idx];
    end
  end

  assign xfer_to_mem_o = ctrl_q[BIT_TO_MEM];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              dev_irq_set,
  input logic              irq_o,
  input logic              dev_reset_o,
  input logic [DATA_W-1:0] ctrl_q
);
  logic is0, is1;
  assign is0 = bus_addr[3:2] == 2'd0;
  assign is1 = bus_addr[3:2] == 2'd1;

  p_version_r2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && is0 && !rst) |-> ctrl_q[DATA_W-1:DATA_W-4] == 4'hA);

  p_reset_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    dev_reset_o == $past(bus_wr && is0 && bus_wdata[7] && !rst));

  p_irq_off_r5: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && is0 && !bus_wdata[4] && !rst) |-> !irq_o);

  p_loaded_r6: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && is1 && !rst) |-> ctrl_q[26]);

  p_pend_set_r7: assert property (@(posedge clk) disable iff (rst)
    $past(dev_irq_set && !rst) |-> ctrl_q[0]);

  p_rvalid_r8: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid == $past(bus_rd && !rst));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rvalid  (bus_rvalid),
  .dev_irq_set (dev_irq_set),
  .irq_o       (irq_o),
  .dev_reset_o (dev_reset_o),
  .ctrl_q      (ctrl_q)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, dev_irq_set = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_o, dev_reset_o, xfer_to_mem_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] m [4];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  dma_chan_regs u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .dev_irq_set(dev_irq_set), .irq_o(irq_o),
    .dev_reset_o(dev_reset_o), .xfer_to_mem_o(xfer_to_mem_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_store(logic [31:0] v);
    logic [31:0] r = v;
    if (!v[7]) begin
      if (v[6]) r[6] = 1'b0;
      else if (v == 32'd0) r[6] = 1'b1;
    end
    r[31:28] = 4'hA;
    return r;
  endfunction

  task automatic model_wr(int idx, logic [31:0] v, bit irqset);
    case (idx)
      0: begin
        m[0] = ctrl_store(v);
        if (v[7]) begin m[1] = 0; m[2] = 0; m[3] = 0; end
      end
      1: begin m[1] = v; m[0][26] = 1'b1; end
      default: m[idx] = v;
    endcase
    if (irqset) m[0][0] = 1'b1;
  endtask

  task automatic wr(int idx, logic [31:0] v, bit irqset = 0, logic [1:0] lo = 2'b00);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {idx[1:0], lo}; bus_wdata = v; dev_irq_set = irqset;
    @(negedge clk);
    bus_wr = 1'b0; dev_irq_set = 1'b0;
    model_wr(idx, v, irqset);
  endtask

  task automatic rd(int idx, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {idx[1:0], 2'b00};
    exp_q.push_back(m[idx]); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 irq_o", {31'd0, irq_o}, 0);
    chk("R9 dev_reset_o", {31'd0, dev_reset_o}, 0);
    chk("R9 rvalid", {31'd0, bus_rvalid}, 0);
    chk("R9 xfer_to_mem_o", {31'd0, xfer_to_mem_o}, 0);
    for (int i = 0; i < 4; i++) rd(i, "R9 reset value");

    // R1 plain storage, low address bits ignored
    wr(2, 32'h1234_5678);
    wr(3, 32'hDEAD_BEEF, 0, 2'b11);
    rd(2, "R1 reg2 readback");
    rd(3, "R1 reg3 low bits ignored");
    chk("R1 reg3 write left ctrl", {31'd0, irq_o}, 0);

    // R2 / R5 version and interrupt combine
    wr(0, 32'h0000_0013);
    chk("R5 irq on pend&en", {31'd0, irq_o}, 1);
    rd(0, "R2 version forced");

    // R4 toggle bit, R10 direction
    wr(0, 32'h5000_0150);
    chk("R10 direction", {31'd0, xfer_to_mem_o}, 1);
    chk("R5 irq off no pend", {31'd0, irq_o}, 0);
    rd(0, "R4 bit6 cleared");
    wr(0, 32'h0);
    chk("R10 direction cleared", {31'd0, xfer_to_mem_o}, 0);
    rd(0, "R4 zero write");

    // R6 loaded flag
    wr(1, 32'h0000_1000);
    rd(0, "R6 loaded flag");
    rd(1, "R6 address stored");

    // R7 interrupt set
    wr(0, 32'h0000_0010);
    @(negedge clk); dev_irq_set = 1'b1;
    @(negedge clk); dev_irq_set = 1'b0; m[0][0] = 1'b1;
    chk("R7 irq after set", {31'd0, irq_o}, 1);
    rd(0, "R7 pending set");

    // R5 disabling write drops irq
    wr(0, 32'h0000_0001);
    chk("R5 irq dropped", {31'd0, irq_o}, 0);

    // R7 collision: write clears bit0 but set wins
    wr(0, 32'h0000_0010, 1);
    chk("R7 collision irq", {31'd0, irq_o}, 1);
    rd(0, "R7 collision pending");

    // R3 reset write
    wr(1, 32'h0000_0ABC);
    wr(2, 32'h0000_1111);
    wr(3, 32'h0000_2222);
    wr(0, 32'h0000_00C0);
    chk("R3 reset pulse", {31'd0, dev_reset_o}, 1);
    chk("R3 irq low", {31'd0, irq_o}, 0);
    @(negedge clk);
    chk("R3 pulse one cycle", {31'd0, dev_reset_o}, 0);
    rd(0, "R3 ctrl keeps bit6");
    rd(1, "R3 reg1 cleared");
    rd(2, "R3 reg2 cleared");
    rd(3, "R3 reg3 cleared");

    repeat (3) @(negedge clk);
    chk("R8 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule